// File: doc/BRIEF.md
# JTAG Master Shift Engine

This block acts as the controlling side of a four-wire test access port. A host issues one command at a time on a parallel interface. The engine then produces TCK, TMS and TDI and collects TDO. There are four commands. One resets the TAP and parks it in Run-Test/Idle. Two others walk the TAP from Run-Test/Idle into Shift-IR or into Shift-DR. The last one shifts a field of 1 to 32 bits.

Every shift sets three options of its own: which end of the word goes out first, whether TMS rises on the final bit to leave the shift state, and whether the TAP goes back to Run-Test/Idle after Update. If a shift does not exit, the TAP stays in its shift state. Several fields of different length and bit order can then be joined inside one scan pass. A shift that exits without the return option leaves the TAP parked in Update. The clock runs at a fixed fraction of the system clock: each half period lasts HALF_DIV system clocks.

Top module: `jtag_shift_master`

## Requirements
- R1: A `start` pulse seen while `busy` is low is accepted. `busy` is high from the next cycle until the command ends. `done` is high for exactly one cycle, and that is the cycle in which `busy` first reads low again. A `start` seen while `busy` is high has no effect on the waveform or on the result.
- R2: Operation code 0 (TAP reset) makes six TCK cycles with TMS values 1, 1, 1, 1, 1, 0.
- R3: Operation code 1 makes four TCK cycles with TMS 1, 1, 0, 0 (to Shift-IR). Operation code 2 makes three TCK cycles with TMS 1, 0, 0 (to Shift-DR).
- R4: TCK is high whenever the engine is idle. Each TCK cycle is HALF_DIV system clocks low followed by HALF_DIV system clocks high. TMS and TDI change only in the cycle in which TCK falls, or in the cycle in which the command ends.
- R5: Operation code 3 (shift) with the exit option clear makes exactly N TCK cycles, with TMS low on all of them.
- R6: With the exit option set, TMS is high on the last data bit. One more TCK cycle follows with TMS high. If the return option is also set, a further cycle follows with TMS low. The return option has no effect when the exit option is clear.
- R7: In LSB-first order, bit 0 of `tx_word` goes out first, and the j-th captured TDO bit ends at `rx_word` bit j. In MSB-first order, bit N-1 goes out first, and the j-th captured bit ends at bit N-1-j. Bits of `rx_word` at N and above read zero.
- R8: TDO is sampled once per data bit, in the last system cycle of that bit's TCK-high phase.
- R9: TDI is high on the exit and return cycles of a shift and after any shift command ends. Commands 0 to 2 leave TDI unchanged. TMS holds its last value while idle.
- R10: `rx_word` changes only at the end of a shift command, in the cycle where `done` is high. Commands 0 to 2 leave it unchanged.
- R11: A length field of 0 is handled as 1. A length above 32 is handled as 32.
- R12: After reset, TCK, TMS and TDI are high, `busy` and `done` are low, and `rx_word` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request |
| op | input | 2 | 0 reset, 1 to Shift-IR, 2 to Shift-DR, 3 shift |
| shift_len | input | LW | Number of bits for a shift |
| msb_first | input | 1 | 1 sends the top bit first |
| end_shift | input | 1 | Raise TMS on the last bit and move on to Update |
| ret_idle | input | 1 | After Update, continue to Run-Test/Idle |
| tx_word | input | W | Data to shift out |
| tdo | input | 1 | Serial data from the TAP |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rx_word | output | W | Captured TDO bits |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial data to the TAP |

## Verification
Each command of S TCK cycles occupies exactly 2·HALF_DIV·S system cycles, counted from the cycle after `start` is taken. `done` and the new `rx_word` are due in the following cycle. The reference model builds the expected TMS/TDI step list on its own, expands it into one expected value per system clock, and compares after every clock edge on the falling edge of `clk`. TDO is driven with fresh random data at the start of each high phase and with inverted data at the start of each low phase, so a sample taken at the wrong point gives the wrong `rx_word`.

// File: rtl/jtag_shift_pkg.sv
package jtag_shift_pkg;
  typedef enum logic [1:0] {
    OP_TAP_RESET = 2'd0,
    OP_GOTO_IR   = 2'd1,
    OP_GOTO_DR   = 2'd2,
    OP_SHIFT     = 2'd3
  } jsm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NAV  = 2'd1,
    ST_DATA = 2'd2
  } jsm_state_e;

  localparam int PAT_W = 6;

  // TMS walk, bit 0 is sent first
  function automatic logic [PAT_W-1:0] nav_pattern(input jsm_op_e o);
    case (o)
      OP_TAP_RESET: return 6'b011111;
      OP_GOTO_IR:   return 6'b000011;
      default:      return 6'b000001;
    endcase
  endfunction

  function automatic logic [2:0] nav_steps(input jsm_op_e o);
    case (o)
      OP_TAP_RESET: return 3'd6;
      OP_GOTO_IR:   return 3'd4;
      default:      return 3'd3;
    endcase
  endfunction
endpackage

// File: rtl/jsm_half_timer.sv
module jsm_half_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic half_end
);
  localparam int HD = (HALF_DIV < 1) ? 1 : HALF_DIV;
  localparam int CW = (HD > 1) ? $clog2(HD) : 1;

  logic [CW-1:0] cnt_q;

  assign half_end = (cnt_q == CW'(HD - 1));

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt_q <= '0;
    else if (half_end) cnt_q <= '0;
    else               cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/jsm_shift_path.sv
module jsm_shift_path #(
  parameter int W  = 32,
  parameter int LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  word_in,
  input  logic [LW-1:0] len_in,
  input  logic          msb_in,
  input  logic          step,
  input  logic          tdo,
  output logic          first_bit,
  output logic          nxt_bit,
  output logic [W-1:0]  word_q,
  output logic [W-1:0]  word_nxt
);
  logic [W-1:0]  sreg_q, mask_q, top_q;
  logic [LW-1:0] len_q;
  logic          msb_q;
  logic [W-1:0]  in_hi, reg_hi;

  function automatic logic [W-1:0] len_mask(input logic [LW-1:0] n);
    return {W{1'b1}} >> (W - int'(n));
  endfunction

  assign in_hi     = word_in >> (len_in - LW'(1));
  assign first_bit = msb_in ? in_hi[0] : word_in[0];
  assign reg_hi    = sreg_q >> (len_q - LW'(2));
  assign nxt_bit   = msb_q ? reg_hi[0] : sreg_q[1];
  assign word_nxt  = msb_q ? (((sreg_q << 1) | W'(tdo)) & mask_q)
                           : ((sreg_q >> 1) | (tdo ? top_q : '0));
  assign word_q    = sreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      mask_q <= '0;
      top_q  <= '0;
      len_q  <= '0;
      msb_q  <= 1'b0;
    end else if (load) begin
      sreg_q <= word_in & len_mask(len_in);
      mask_q <= len_mask(len_in);
      top_q  <= W'(1) << (len_in - LW'(1));
      len_q  <= len_in;
      msb_q  <= msb_in;
    end else if (step) begin
      sreg_q <= word_nxt;
    end
  end
endmodule

// File: rtl/jtag_shift_master.sv
module jtag_shift_master
  import jtag_shift_pkg::*;
#(
  parameter int W        = 32,
  parameter int HALF_DIV = 2,
  parameter int LW       = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [LW-1:0] shift_len,
  input  logic          msb_first,
  input  logic          end_shift,
  input  logic          ret_idle,
  input  logic [W-1:0]  tx_word,
  input  logic          tdo,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  rx_word,
  output logic          tck,
  output logic          tms,
  output logic          tdi
);
  jsm_state_e       state_q;
  jsm_op_e          op_in;
  logic             tck_q, tms_q, tdi_q, done_q;
  logic [W-1:0]     rx_q;
  logic [PAT_W-1:0] pat_q;
  logic [2:0]       nav_left_q;
  logic [LW-1:0]    bits_left_q, len_eff;
  logic             end_q, ret_q, is_shift_q;
  logic             half_end, accept, dp_step;
  logic             dp_first, dp_nxt;
  logic [W-1:0]     dp_word, dp_word_nxt;

  assign op_in   = jsm_op_e'(op);
  assign len_eff = (shift_len == '0)         ? LW'(1) :
                   (int'(shift_len) > W)     ? LW'(W) : shift_len;
  assign accept  = start && (state_q == ST_IDLE);
  assign dp_step = (state_q == ST_DATA) && half_end && tck_q;

  jsm_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (state_q != ST_IDLE),
    .half_end (half_end)
  );

  jsm_shift_path #(.W(W), .LW(LW)) u_path (
    .clk       (clk),
    .rst       (rst),
    .load      (accept && (op_in == OP_SHIFT)),
    .word_in   (tx_word),
    .len_in    (len_eff),
    .msb_in    (msb_first),
    .step      (dp_step),
    .tdo       (tdo),
    .first_bit (dp_first),
    .nxt_bit   (dp_nxt),
    .word_q    (dp_word),
    .word_nxt  (dp_word_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      tck_q       <= 1'b1;
      tms_q       <= 1'b1;
      tdi_q       <= 1'b1;
      done_q      <= 1'b0;
      rx_q        <= '0;
      pat_q       <= '0;
      nav_left_q  <= '0;
      bits_left_q <= '0;
      end_q       <= 1'b0;
      ret_q       <= 1'b0;
      is_shift_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            tck_q      <= 1'b0;
            is_shift_q <= (op_in == OP_SHIFT);
            if (op_in == OP_SHIFT) begin
              state_q     <= ST_DATA;
              bits_left_q <= len_eff;
              end_q       <= end_shift;
              ret_q       <= ret_idle;
              tdi_q       <= dp_first;
              tms_q       <= end_shift && (len_eff == LW'(1));
            end else begin
              state_q    <= ST_NAV;
              pat_q      <= nav_pattern(op_in);
              nav_left_q <= nav_steps(op_in);
              tms_q      <= nav_pattern(op_in)[0];
            end
          end
        end
        ST_NAV: begin
          if (half_end) begin
            if (!tck_q) begin
              tck_q <= 1'b1;
            end else if (nav_left_q > 3'd1) begin
              tck_q      <= 1'b0;
              pat_q      <= pat_q >> 1;
              nav_left_q <= nav_left_q - 3'd1;
              tms_q      <= pat_q[1];
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              if (is_shift_q) rx_q <= dp_word;
            end
          end
        end
        ST_DATA: begin
          if (half_end) begin
            if (!tck_q) begin
              tck_q <= 1'b1;
            end else if (bits_left_q > LW'(1)) begin
              tck_q       <= 1'b0;
              bits_left_q <= bits_left_q - LW'(1);
              tdi_q       <= dp_nxt;
              tms_q       <= end_q && (bits_left_q == LW'(2));
            end else begin
              tdi_q <= 1'b1;
              if (end_q) begin
                state_q    <= ST_NAV;
                tck_q      <= 1'b0;
                tms_q      <= 1'b1;
                pat_q      <= PAT_W'(1);
                nav_left_q <= ret_q ? 3'd2 : 3'd1;
              end else begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                rx_q    <= dp_word_nxt;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign rx_word = rx_q;
  assign tck     = tck_q;
  assign tms     = tms_q;
  assign tdi     = tdi_q;
endmodule

// File: rtl/jtag_shift_master_chk.sv
module jtag_shift_master_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         tck,
  input logic         tms,
  input logic         tdi,
  input logic [W-1:0] rx_word
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                        // R1
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));                        // R1
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> (busy || done));            // R1
  AST_TCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tck);                                         // R4
  AST_TMS_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(tms) |-> $fell(tck));                          // R4
  AST_TDI_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(tdi) |-> ($fell(tck) || $fell(busy)));         // R4
  AST_RX_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_word) |-> done);                            // R10
endmodule

bind jtag_shift_master jtag_shift_master_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .tck     (tck),
  .tms     (tms),
  .tdi     (tdi),
  .rx_word (rx_word)
);

// File: tb/jtag_shift_master_tb.sv
module jtag_shift_master_tb;
  localparam int W  = 32;
  localparam int H  = 2;
  localparam int LW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [LW-1:0] shift_len = '0;
  logic          msb_first = 1'b0, end_shift = 1'b0, ret_idle = 1'b0;
  logic [W-1:0]  tx_word = '0;
  logic          tdo = 1'b0;
  logic          busy, done, tck, tms, tdi;
  logic [W-1:0]  rx_word;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [15:0]  lfsr = 16'hACE1;
  logic         cur_tms, cur_tdi;
  logic [W-1:0] cur_rx;

  always #5 clk = ~clk;

  jtag_shift_master #(.W(W), .HALF_DIV(H)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .shift_len(shift_len),
    .msb_first(msb_first), .end_shift(end_shift), .ret_idle(ret_idle),
    .tx_word(tx_word), .tdo(tdo), .busy(busy), .done(done),
    .rx_word(rx_word), .tck(tck), .tms(tms), .tdi(tdi)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // Issue a command and compare every system clock with the model
  task automatic run_cmd(input logic [1:0] o, input int len, input logic msb,
                         input logic e, input logic r, input logic [W-1:0] tx,
                         input bit poke, input string tag);
    logic q_tms[$];
    logic q_tdi[$];
    logic cap[$];
    int n, total;
    logic [W-1:0] exp_rx;
    n = (len == 0) ? 1 : (len > W ? W : len);             // R11
    case (o)
      2'd0: begin q_tms = '{1,1,1,1,1,0}; end               // R2
      2'd1: begin q_tms = '{1,1,0,0}; end                   // R3
      2'd2: begin q_tms = '{1,0,0}; end                     // R3
      default: begin
        for (int i = 0; i < n; i++) begin                  // R5 R7
          q_tms.push_back(e && (i == n - 1));
          q_tdi.push_back(msb ? tx[n-1-i] : tx[i]);
        end
        if (e) begin q_tms.push_back(1'b1); q_tdi.push_back(1'b1); end  // R6 R9
        if (e && r) begin q_tms.push_back(1'b0); q_tdi.push_back(1'b1); end
      end
    endcase
    if (o != 2'd3) foreach (q_tms[i]) q_tdi.push_back(cur_tdi);         // R9
    total = q_tms.size() * 2 * H;

    @(negedge clk);
    op = o; shift_len = LW'(len); msb_first = msb; end_shift = e;
    ret_idle = r; tx_word = tx; start = 1'b1;
    for (int c = 0; c <= total; c++) begin
      @(negedge clk);
      if (c == 0) start = 1'b0;
      if (poke && c == 3) begin start = 1'b1; op = 2'd0; tx_word = ~tx; end
      if (poke && c == 4) begin start = 1'b0; op = o; tx_word = tx; end
      if (c < total) begin
        int s, ph;
        s  = c / (2 * H);
        ph = c % (2 * H);
        check({busy, done} == 2'b10, "R1", W'({busy, done}), W'(2'b10));
        check(tck == (ph >= H), "R4", W'(tck), W'(ph >= H));
        check({tms, tdi} == {q_tms[s], q_tdi[s]}, tag, W'({tms, tdi}), W'({q_tms[s], q_tdi[s]}));
        if (o == 2'd3 && s < n) begin
          if (ph == H) begin tdo = next_rand(); cap.push_back(tdo); end  // R8
          else if (ph == 0) tdo = ~lfsr[0];
        end
      end else begin
        exp_rx = cur_rx;
        if (o == 2'd3) begin
          exp_rx = '0;
          for (int j = 0; j < n; j++) exp_rx[msb ? n-1-j : j] = cap[j];
        end
        check({busy, done, tck} == 3'b011, "R1", W'({busy, done, tck}), W'(3'b011));
        check(tms == q_tms[q_tms.size()-1], "R9", W'(tms), W'(q_tms[q_tms.size()-1]));
        check(tdi == ((o == 2'd3) ? 1'b1 : cur_tdi), "R9", W'(tdi), W'((o == 2'd3) ? 1'b1 : cur_tdi));
        check(rx_word == exp_rx, (o == 2'd3) ? "R7 R8" : "R10", rx_word, exp_rx);
        cur_rx  = exp_rx;
        cur_tms = q_tms[q_tms.size()-1];
        cur_tdi = (o == 2'd3) ? 1'b1 : cur_tdi;
      end
    end
    @(negedge clk);
    check({busy, done, tck} == 3'b001, "R1", W'({busy, done, tck}), W'(3'b001));
    check(rx_word == cur_rx, "R10", rx_word, cur_rx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check({tck, tms, tdi, busy, done} == 5'b11100, "R12", W'({tck, tms, tdi, busy, done}), W'(5'b11100));
    check(rx_word == '0, "R12", rx_word, '0);
    cur_tms = 1'b1; cur_tdi = 1'b1; cur_rx = '0;

    run_cmd(2'd0, 0, 0, 0, 0, '0, 1, "R2");                         // R1 start while busy ignored
    run_cmd(2'd2, 0, 0, 0, 0, '0, 0, "R3");
    run_cmd(2'd3, 32, 0, 0, 1, 32'hC3A5_0F96, 1, "R5");              // no exit, ret ignored (R6)
    run_cmd(2'd3, 5, 1, 1, 0, 32'h0000_0016, 0, "R6");              // stop in Update
    run_cmd(2'd1, 0, 0, 0, 0, '0, 0, "R3");
    run_cmd(2'd3, 4, 0, 1, 1, 32'hFFFF_FFF9, 0, "R6");
    run_cmd(2'd2, 0, 0, 0, 0, '0, 0, "R3");                          // R10 rx held
    run_cmd(2'd3, 1, 0, 1, 1, 32'h0000_0000, 0, "R6");
    run_cmd(2'd3, 0, 1, 0, 0, 32'h0000_0001, 0, "R11");
    run_cmd(2'd3, 40, 1, 1, 1, 32'h8123_4567, 0, "R11");
    run_cmd(2'd3, 17, 1, 0, 0, 32'h0001_B00D, 0, "R7");
    run_cmd(2'd0, 0, 0, 0, 0, '0, 0, "R2");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule